// File: doc/BRIEF.md
# DRAM Read/Write Turnaround Arbiter

This block sits beside the read and write request queues of a DRAM controller and decides, one cycle at a time, which direction the data bus serves. It watches the occupancy of both queues and a ready signal from the command stage. It produces a registered direction flag and a pop strobe for the queue being served. Writes are held back so that they can be issued in long bursts. They drain when the write queue crosses a high watermark, or when no read is waiting. Once draining, the arbiter keeps serving writes until the backlog falls to a low watermark, and it requires a minimum number of write bursts before it turns back to reads. This stops the direction from flipping back and forth near the threshold.

For statistics, the block counts the bursts issued in each direction since the last direction change. When a change happens it latches the totals of the period that just ended, and it counts the total number of turnarounds.

Top module: `dram_turnaround_arb`

## Requirements
- R1: After reset `wrMode` is 0 (read direction) and every counter output is 0.
- R2: `rdPop` is high only when `wrMode` is 0, `rdOcc` is non-zero and `cmdReady` is high. `wrPop` is high only when `wrMode` is 1, `wrOcc` is non-zero and `cmdReady` is high. Both pops are combinational in the current cycle.
- R3: In read direction, a cycle with `rdOcc` equal to 0 and `wrOcc` non-zero makes `wrMode` 1 at the next clock edge, even below the high watermark. With both queues empty the direction stays read.
- R4: In read direction, `wrOcc` at or above `HI_MARK` makes `wrMode` 1 at the next edge, even when reads are pending or `cmdReady` is low.
- R5: In write direction, `wrMode` stays 1 while `wrOcc` is above `LO_MARK`.
- R6: A return from write to read when `wrOcc` is non-zero needs three conditions together: reads are pending, `wrOcc` is at most `LO_MARK`, and at least `MIN_WR_BURSTS` writes have been issued since entering write direction.
- R7: In write direction, `wrOcc` equal to 0 makes `wrMode` 0 at the next edge.
- R8: On each direction change, `rdBursts` and `wrBursts` restart at 0. `lastRdBursts` and `lastWrBursts` take the totals of the ending period, including a pop made in the switching cycle.
- R9: `turnCount` increases by one on every direction change.
- R10: The parameters must satisfy `LO_MARK < HI_MARK <= WR_DEPTH`, or elaboration stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdOcc | input | $clog2(RD_DEPTH+1) | Read queue occupancy |
| wrOcc | input | $clog2(WR_DEPTH+1) | Write queue occupancy |
| cmdReady | input | 1 | Command stage accepts the selected request |
| wrMode | output | 1 | Current direction: 0 read, 1 write |
| rdPop | output | 1 | Pop the read queue this cycle |
| wrPop | output | 1 | Pop the write queue this cycle |
| rdBursts | output | CNT_W | Reads issued in the current period |
| wrBursts | output | CNT_W | Writes issued in the current period |
| lastRdBursts | output | CNT_W | Reads issued in the previous period |
| lastWrBursts | output | CNT_W | Writes issued in the previous period |
| turnCount | output | CNT_W | Number of direction changes since reset |

## Verification
Some rules are checked by assertions on every cycle. These are the pop qualification, the forced switch at the high watermark, the opportunistic entry into write direction, the hold above the low watermark, the exit on an empty write queue, and the counter restart and increment at each change. Other behaviour needs a scripted history and is shown only by the bench's scenarios. That covers the minimum-burst hysteresis, which depends on how many writes came earlier in the period. It also covers the latched totals that include the pop from the switching cycle, and the order of events across several turnarounds.

// File: rtl/dta_pkg.sv
package dta_pkg;
  // Strobes from control to statistics datapath
  typedef struct packed {
    logic popRd;
    logic popWr;
    logic switchDir;
  } dta_strobe_t;
endpackage

// File: rtl/dta_ctrl.sv
module dta_ctrl
  import dta_pkg::*;
#(
  parameter int RD_OW         = 6,
  parameter int WR_OW         = 7,
  parameter int HI_MARK       = 54,
  parameter int LO_MARK       = 32,
  parameter int MIN_WR_BURSTS = 16,
  parameter int CNT_W         = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RD_OW-1:0] rdOcc,
  input  logic [WR_OW-1:0] wrOcc,
  input  logic             cmdReady,
  input  logic [CNT_W-1:0] wrBurstsNow,
  output logic             isWrite,
  output dta_strobe_t      strobe
);
  localparam logic [WR_OW-1:0] HI_V  = WR_OW'(HI_MARK);
  localparam logic [WR_OW-1:0] LO_V  = WR_OW'(LO_MARK);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_WR_BURSTS);

  logic rdPending, wrPending, nextWrite;

  assign rdPending = (rdOcc != '0);
  assign wrPending = (wrOcc != '0);

  always_comb begin
    if (!isWrite) begin
      nextWrite = (wrOcc >= HI_V) || (!rdPending && wrPending);
    end else if (!wrPending) begin
      nextWrite = 1'b0;
    end else begin
      nextWrite = !(rdPending && (wrOcc <= LO_V) && (wrBurstsNow >= MIN_V));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) isWrite <= 1'b0;
    else       isWrite <= nextWrite;
  end

  assign strobe.popRd     = !isWrite && rdPending && cmdReady;
  assign strobe.popWr     = isWrite && wrPending && cmdReady;
  assign strobe.switchDir = (nextWrite != isWrite);

  // R2: a pop needs a non-empty queue, readiness and the matching direction
  p_pop_qualified_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popRd |-> (rdPending && cmdReady && !isWrite)) and
    (strobe.popWr |-> (wrPending && cmdReady && isWrite)));

  // R3: with no reads waiting, pending writes start draining
  p_opportunistic_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!isWrite && !rdPending && wrPending) |=> isWrite);

  // R4: the high watermark forces write direction
  p_high_mark_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!isWrite && (wrOcc >= HI_V)) |=> isWrite);

  // R5: draining continues above the low watermark
  p_hold_above_lo_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isWrite && (wrOcc > LO_V)) |=> isWrite);

  // R7: an empty write queue ends write direction
  p_empty_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isWrite && !wrPending) |=> !isWrite);
endmodule

// File: rtl/dta_stats.sv
module dta_stats
  import dta_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dta_strobe_t      strobe,
  output logic [CNT_W-1:0] rdBursts,
  output logic [CNT_W-1:0] wrBursts,
  output logic [CNT_W-1:0] lastRdBursts,
  output logic [CNT_W-1:0] lastWrBursts,
  output logic [CNT_W-1:0] turnCount
);
  logic [CNT_W-1:0] rdSum, wrSum;

  assign rdSum = rdBursts + CNT_W'(strobe.popRd);
  assign wrSum = wrBursts + CNT_W'(strobe.popWr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBursts     <= '0;
      wrBursts     <= '0;
      lastRdBursts <= '0;
      lastWrBursts <= '0;
      turnCount    <= '0;
    end else if (strobe.switchDir) begin
      lastRdBursts <= rdSum;
      lastWrBursts <= wrSum;
      rdBursts     <= '0;
      wrBursts     <= '0;
      turnCount    <= turnCount + 1'b1;
    end else begin
      rdBursts <= rdSum;
      wrBursts <= wrSum;
    end
  end

  // R8: per-period counters restart after a direction change
  p_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.switchDir |=> (rdBursts == '0 && wrBursts == '0));

  // R9: each change advances the turnaround count by one
  p_turn_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.switchDir |=> (turnCount == $past(turnCount) + 1'b1));
endmodule

// File: rtl/dram_turnaround_arb.sv
module dram_turnaround_arb
  import dta_pkg::*;
#(
  parameter int RD_DEPTH      = 32,
  parameter int WR_DEPTH      = 64,
  parameter int HI_MARK       = 54,
  parameter int LO_MARK       = 32,
  parameter int MIN_WR_BURSTS = 16,
  parameter int CNT_W         = 16,
  localparam int RD_OW        = $clog2(RD_DEPTH + 1),
  localparam int WR_OW        = $clog2(WR_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RD_OW-1:0] rdOcc,
  input  logic [WR_OW-1:0] wrOcc,
  input  logic             cmdReady,
  output logic             wrMode,
  output logic             rdPop,
  output logic             wrPop,
  output logic [CNT_W-1:0] rdBursts,
  output logic [CNT_W-1:0] wrBursts,
  output logic [CNT_W-1:0] lastRdBursts,
  output logic [CNT_W-1:0] lastWrBursts,
  output logic [CNT_W-1:0] turnCount
);
  // R10: watermark ordering
  generate
    if (!(LO_MARK < HI_MARK && HI_MARK <= WR_DEPTH)) begin : g_bad_marks
      $error("watermarks must satisfy LO_MARK < HI_MARK <= WR_DEPTH");
    end
  endgenerate

  dta_strobe_t strobe;

  dta_ctrl #(
    .RD_OW(RD_OW), .WR_OW(WR_OW), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK),
    .MIN_WR_BURSTS(MIN_WR_BURSTS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rdOcc(rdOcc), .wrOcc(wrOcc),
    .cmdReady(cmdReady), .wrBurstsNow(wrBursts),
    .isWrite(wrMode), .strobe(strobe)
  );

  dta_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdBursts(rdBursts), .wrBursts(wrBursts),
    .lastRdBursts(lastRdBursts), .lastWrBursts(lastWrBursts),
    .turnCount(turnCount)
  );

  assign rdPop = strobe.popRd;
  assign wrPop = strobe.popWr;
endmodule

// File: tb/tb_dram_turnaround_arb.sv
`timescale 1ns/1ps
module tb_dram_turnaround_arb;
  localparam int RD_DEPTH = 8, WR_DEPTH = 16, HI = 12, LO = 6, MINW = 3, CW = 8;

  logic clk = 1'b0, rstN = 1'b0, cmdReady = 1'b0;
  logic [3:0] rdOcc = '0;
  logic [4:0] wrOcc = '0;
  logic wrMode, rdPop, wrPop;
  logic [CW-1:0] rdBursts, wrBursts, lastRd, lastWr, turnCount;

  always #2.5 clk = ~clk;

  dram_turnaround_arb #(
    .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH), .HI_MARK(HI), .LO_MARK(LO),
    .MIN_WR_BURSTS(MINW), .CNT_W(CW)
  ) dut (
    .clk(clk), .rstN(rstN), .rdOcc(rdOcc), .wrOcc(wrOcc), .cmdReady(cmdReady),
    .wrMode(wrMode), .rdPop(rdPop), .wrPop(wrPop), .rdBursts(rdBursts),
    .wrBursts(wrBursts), .lastRdBursts(lastRd), .lastWrBursts(lastWr),
    .turnCount(turnCount)
  );

  typedef struct packed {
    logic [3:0] rd;
    logic [4:0] wr;
    logic       rdy;
    logic       eRdPop;
    logic       eWrPop;
    logic       eMode;
    logic [7:0] eTurn;
    logic [7:0] eLastRd;
    logic [7:0] eLastWr;
  } vec_t;

  // rd, wr, rdy | pops before edge | mode, turns, last totals after edge
  localparam vec_t VEC [13] = '{
    '{4'd3, 5'd2,  1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 8'd0, 8'd0}, // R2 read pop
    '{4'd3, 5'd12, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1, 8'd1, 8'd0}, // R4 high mark, stalled
    '{4'd3, 5'd11, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1, 8'd1, 8'd0}, // R5
    '{4'd3, 5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 8'd1, 8'd1, 8'd0}, // R6 1 burst only
    '{4'd3, 5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 8'd1, 8'd1, 8'd0}, // R6 2 bursts
    '{4'd3, 5'd7,  1'b1, 1'b0, 1'b1, 1'b1, 8'd1, 8'd1, 8'd0}, // R5 above low mark
    '{4'd3, 5'd6,  1'b1, 1'b0, 1'b1, 1'b0, 8'd2, 8'd0, 8'd5}, // R6 exit, R8 totals
    '{4'd0, 5'd2,  1'b1, 1'b0, 1'b0, 1'b1, 8'd3, 8'd0, 8'd0}, // R3 opportunistic
    '{4'd0, 5'd2,  1'b1, 1'b0, 1'b1, 1'b1, 8'd3, 8'd0, 8'd0}, // R3 stays, no reads
    '{4'd2, 5'd1,  1'b1, 1'b0, 1'b1, 1'b1, 8'd3, 8'd0, 8'd0}, // R6 hysteresis holds
    '{4'd2, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 8'd4, 8'd0, 8'd2}, // R7 empty exit
    '{4'd0, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 8'd4, 8'd0, 8'd2}, // R3 both empty
    '{4'd8, 5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 8'd4, 8'd0, 8'd2}  // R2
  };

  int nChecks = 0, nFails = 0;

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1", "wrMode", 16'(wrMode), 16'd0);
    chk("R1", "turnCount", 16'(turnCount), 16'd0);
    chk("R1", "bursts", 16'(rdBursts | wrBursts | lastRd | lastWr), 16'd0);

    for (int i = 0; i < 13; i++) begin
      rdOcc = VEC[i].rd; wrOcc = VEC[i].wr; cmdReady = VEC[i].rdy;
      #1;
      chk("R2", "rdPop", 16'(rdPop), 16'(VEC[i].eRdPop));
      chk("R2", "wrPop", 16'(wrPop), 16'(VEC[i].eWrPop));
      @(posedge clk); #1;
      chk("R3-7", "wrMode", 16'(wrMode), 16'(VEC[i].eMode));
      chk("R9", "turnCount", 16'(turnCount), 16'(VEC[i].eTurn));
      chk("R8", "lastRdBursts", 16'(lastRd), 16'(VEC[i].eLastRd));
      chk("R8", "lastWrBursts", 16'(lastWr), 16'(VEC[i].eLastWr));
      @(negedge clk);
    end

    // R8: live read count of the current period (one pop since last change)
    chk("R8", "rdBursts", 16'(rdBursts), 16'd1);

    // R4 with reads pending; R8 total includes the switching-cycle pop
    rdOcc = 4'd3; wrOcc = 5'd12; cmdReady = 1'b1;
    @(posedge clk); #1;
    chk("R4", "wrMode", 16'(wrMode), 16'd1);
    chk("R8", "lastRdBursts", 16'(lastRd), 16'd2);
    chk("R8", "rdBursts", 16'(rdBursts), 16'd0);
    chk("R9", "turnCount", 16'(turnCount), 16'd5);

    // R1 mid-run reset
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R1", "wrMode", 16'(wrMode), 16'd0);
    chk("R1", "turnCount", 16'(turnCount), 16'd0);
    chk("R1", "lastRdBursts", 16'(lastRd), 16'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule